// File: doc/BRIEF.md
# MAC Warm Reset Sequencer

This block takes one transmit or receive path of a MAC through a warm reset with no help from software. It is a master on a simple register bus. A start pulse launches a fixed two-phase protocol. In the stop phase it reads the path's configuration register and keeps a copy. It writes the value back with the path enable cleared, lets traffic drain for a fixed interval, and then polls a state register until the path's state field reads zero. In the reset phase it read-modify-writes the path's self-clearing software-reset register and polls it until the reset bits clear. It finishes by writing the saved configuration back.

Two register layouts are supported, selected per run: a 10G-style MAC and a 1G-style MAC. The layout decides the register offsets, the enable bit, the idle field, the reset bits, the drain interval and the idle poll period. The direction select picks the transmit or receive variant of each. Every address is a layout offset added to a per-port base. Each poll loop is bounded. A loop that never sees the value it waits for ends the run with a sticky error flag and leaves the configuration unrestored.

Top module: `mac_warm_rst_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. On acceptance the MAC type, direction and port base are captured and `busy_o` rises on the next cycle. A start while busy, and any change of the selects or base during a run, has no effect on the access sequence.
- R2: The run opens with a read of the configuration register, then a write of that same value with the enable bit cleared and all other bits kept. Configuration offsets are 0x060 for the 10G type in both directions, 0xC060 for 1G transmit and 0xC068 for 1G receive. The enable bit is bit 0, except for 10G receive, where it is bit 8.
- R3: The first state-register read is requested DRAIN_XG (10G) or DRAIN_GE (1G) clock cycles after the cycle in which the disabling write completes. The defaults are 3000 and 30000.
- R4: The state register sits at offset 0x1A8 (10G) or 0xC3A0 (1G). The path is idle when its field reads zero: bits [2:0] for 10G transmit, bit 7 for 10G receive, bits [19:16] for 1G transmit and bits [26:23] for 1G receive. Bits outside the field are ignored. Each non-idle read is followed by another read POLL_XG (100) or POLL_GE (1000) cycles after it completes.
- R5: No access to the software-reset register is made before a state read has returned the idle field as zero. The reset-register read follows that read directly.
- R6: The reset register sits at offset 0x000 (10G transmit), 0x008 (10G receive), 0xC000 (1G transmit) or 0xC008 (1G receive). It is read, then written with the read value OR 0x3 (10G) or OR 0x1 (1G).
- R7: After the reset write, the reset register is read every RST_POLL (100) cycles, counted from the completion of the previous access, until the bits that were set read back zero.
- R8: After the reset bits clear, the saved configuration value is written back unchanged. In the cycle after that write completes, `done_o` is high for one cycle while `busy_o` is low.
- R9: Each poll loop accepts up to LIMIT_TX (100) or LIMIT_RX (10) non-idle reads. The next non-idle read ends the run: `err_o` and `done_o` rise together in the following cycle and no further bus access is made, so the configuration is not restored.
- R10: `err_o` stays high until the next accepted start. It clears in the cycle after that start.
- R11: A bus request holds its address, write flag and write data until `bus_ready_i` is high at a clock edge. That edge completes the access, and the sequencer never advances past an access without it.
- R12: While reset is asserted, `busy_o`, `done_o`, `err_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| kind_i | input | 1 | MAC layout: 0 = 10G type, 1 = 1G type |
| dir_i | input | 1 | Path: 0 = transmit, 1 = receive |
| port_base_i | input | ADDR_W | Port base added to every register offset |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ready_i | input | 1 | Access completes at this clock edge |
| bus_rdata_i | input | DATA_W | Read data, valid with ready |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky poll timeout flag |

## Verification
A wrong sequencer state shows up on the bus within one access. It appears as a wrong offset, a mask applied to the wrong bit, a missing read-modify-write, or an access issued early. A wrong wait count or a loop counter off by one shifts the next request by whole cycles, or changes the number of reads before the error, so it is visible at the request that follows the gap. A corrupted saved copy is visible in the restoring write. A wrong end-of-run state is visible in the cycle after the last access, through `done_o`, `busy_o` and `err_o`.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

   typedef enum logic {
      KIND_XG = 1'b0,
      KIND_GE = 1'b1
   } mac_kind_e;

   typedef enum logic {
      PATH_TX = 1'b0,
      PATH_RX = 1'b1
   } path_dir_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CFG_RD,
      ST_CFG_WR,
      ST_DRAIN,
      ST_IDLE_RD,
      ST_IDLE_GAP,
      ST_RST_RD,
      ST_RST_WR,
      ST_RST_GAP,
      ST_RST_CHK,
      ST_RESTORE,
      ST_FIN
   } seq_state_e;

   // register offsets, 10G-style layout
   localparam logic [15:0] XG_CFG_OFS    = 16'h0060;
   localparam logic [15:0] XG_SM_OFS     = 16'h01A8;
   localparam logic [15:0] XG_RST_TX_OFS = 16'h0000;
   localparam logic [15:0] XG_RST_RX_OFS = 16'h0008;
   // register offsets, 1G-style layout
   localparam logic [15:0] GE_CFG_TX_OFS = 16'hC060;
   localparam logic [15:0] GE_CFG_RX_OFS = 16'hC068;
   localparam logic [15:0] GE_SM_OFS     = 16'hC3A0;
   localparam logic [15:0] GE_RST_TX_OFS = 16'hC000;
   localparam logic [15:0] GE_RST_RX_OFS = 16'hC008;

   // enable bit positions
   localparam int XG_TX_EN_BIT = 0;
   localparam int XG_RX_EN_BIT = 8;
   localparam int GE_EN_BIT    = 0;

   // idle field bounds inside the state register
   localparam int XG_TX_FLD_LO = 0;
   localparam int XG_TX_FLD_HI = 2;
   localparam int XG_RX_FLD_LO = 7;
   localparam int XG_RX_FLD_HI = 7;
   localparam int GE_TX_FLD_LO = 16;
   localparam int GE_TX_FLD_HI = 19;
   localparam int GE_RX_FLD_LO = 23;
   localparam int GE_RX_FLD_HI = 26;

   // self-clearing reset bits
   localparam int XG_RST_BITS = 3;
   localparam int GE_RST_BITS = 1;

endpackage

// File: rtl/mwr_profile.sv
module mwr_profile
   import mwr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int TMR_W    = 15,
   parameter int LIM_W    = 7,
   parameter int DRAIN_XG = 3000,
   parameter int DRAIN_GE = 30000,
   parameter int POLL_XG  = 100,
   parameter int POLL_GE  = 1000,
   parameter int RST_POLL = 100,
   parameter int LIMIT_TX = 100,
   parameter int LIMIT_RX = 10
) (
   input  logic              kind_i,
   input  logic              dir_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] cfg_addr_o,
   output logic [ADDR_W-1:0] sm_addr_o,
   output logic [ADDR_W-1:0] rst_addr_o,
   output logic [DATA_W-1:0] en_mask_o,
   output logic [DATA_W-1:0] idle_mask_o,
   output logic [DATA_W-1:0] rst_mask_o,
   output logic [TMR_W-1:0]  drain_rld_o,
   output logic [TMR_W-1:0]  poll_rld_o,
   output logic [TMR_W-1:0]  rst_rld_o,
   output logic [LIM_W-1:0]  limit_o
);

   localparam int IDX_W = $clog2(DATA_W) + 1;

   logic [15:0]      cfg_ofs, sm_ofs, rst_ofs;
   logic [IDX_W-1:0] fld_lo, fld_hi, en_pos;

   always_comb begin
      cfg_ofs = XG_CFG_OFS;
      sm_ofs  = XG_SM_OFS;
      rst_ofs = XG_RST_TX_OFS;
      fld_lo  = IDX_W'(XG_TX_FLD_LO);
      fld_hi  = IDX_W'(XG_TX_FLD_HI);
      en_pos  = IDX_W'(XG_TX_EN_BIT);
      unique case ({kind_i, dir_i})
         {KIND_XG, PATH_TX}: begin
            cfg_ofs = XG_CFG_OFS;
            sm_ofs  = XG_SM_OFS;
            rst_ofs = XG_RST_TX_OFS;
            fld_lo  = IDX_W'(XG_TX_FLD_LO);
            fld_hi  = IDX_W'(XG_TX_FLD_HI);
            en_pos  = IDX_W'(XG_TX_EN_BIT);
         end
         {KIND_XG, PATH_RX}: begin
            cfg_ofs = XG_CFG_OFS;
            sm_ofs  = XG_SM_OFS;
            rst_ofs = XG_RST_RX_OFS;
            fld_lo  = IDX_W'(XG_RX_FLD_LO);
            fld_hi  = IDX_W'(XG_RX_FLD_HI);
            en_pos  = IDX_W'(XG_RX_EN_BIT);
         end
         {KIND_GE, PATH_TX}: begin
            cfg_ofs = GE_CFG_TX_OFS;
            sm_ofs  = GE_SM_OFS;
            rst_ofs = GE_RST_TX_OFS;
            fld_lo  = IDX_W'(GE_TX_FLD_LO);
            fld_hi  = IDX_W'(GE_TX_FLD_HI);
            en_pos  = IDX_W'(GE_EN_BIT);
         end
         default: begin
            cfg_ofs = GE_CFG_RX_OFS;
            sm_ofs  = GE_SM_OFS;
            rst_ofs = GE_RST_RX_OFS;
            fld_lo  = IDX_W'(GE_RX_FLD_LO);
            fld_hi  = IDX_W'(GE_RX_FLD_HI);
            en_pos  = IDX_W'(GE_EN_BIT);
         end
      endcase
   end

   assign cfg_addr_o = base_i + ADDR_W'(cfg_ofs);
   assign sm_addr_o  = base_i + ADDR_W'(sm_ofs);
   assign rst_addr_o = base_i + ADDR_W'(rst_ofs);

   // one mask bit per data bit, set where the bit lies in the idle field
   for (genvar b = 0; b < DATA_W; b++) begin : g_fld
      assign idle_mask_o[b] = (IDX_W'(b) >= fld_lo) && (IDX_W'(b) <= fld_hi);
      assign en_mask_o[b]   = (IDX_W'(b) == en_pos);
   end

   assign rst_mask_o  = (kind_i == KIND_GE) ? DATA_W'(GE_RST_BITS) : DATA_W'(XG_RST_BITS);
   assign drain_rld_o = (kind_i == KIND_GE) ? TMR_W'(DRAIN_GE - 1) : TMR_W'(DRAIN_XG - 1);
   assign poll_rld_o  = (kind_i == KIND_GE) ? TMR_W'(POLL_GE - 1) : TMR_W'(POLL_XG - 1);
   assign rst_rld_o   = TMR_W'(RST_POLL - 1);
   assign limit_o     = (dir_i == PATH_RX) ? LIM_W'(LIMIT_RX) : LIM_W'(LIMIT_TX);

endmodule

// File: rtl/mwr_timer.sv
module mwr_timer #(
   parameter int W = 15
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] value_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (load_i)       cnt_q <= value_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mwr_tally.sv
module mwr_tally #(
   parameter int W = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + W'(1);
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/mac_warm_rst_seq.sv
module mac_warm_rst_seq
   import mwr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int DRAIN_XG = 3000,
   parameter int DRAIN_GE = 30000,
   parameter int POLL_XG  = 100,
   parameter int POLL_GE  = 1000,
   parameter int RST_POLL = 100,
   parameter int LIMIT_TX = 100,
   parameter int LIMIT_RX = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              kind_i,
   input  logic              dir_i,
   input  logic [ADDR_W-1:0] port_base_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ready_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int DRAIN_MAX = (DRAIN_XG > DRAIN_GE) ? DRAIN_XG : DRAIN_GE;
   localparam int POLL_MAX0 = (POLL_XG > POLL_GE) ? POLL_XG : POLL_GE;
   localparam int POLL_MAX  = (POLL_MAX0 > RST_POLL) ? POLL_MAX0 : RST_POLL;
   localparam int WAIT_MAX  = (DRAIN_MAX > POLL_MAX) ? DRAIN_MAX : POLL_MAX;
   localparam int TMR_W     = $clog2(WAIT_MAX + 1);
   localparam int LIM_MAX   = (LIMIT_TX > LIMIT_RX) ? LIMIT_TX : LIMIT_RX;
   localparam int LIM_W     = $clog2(LIM_MAX + 1);

   // elaboration-time parameter checks
   if (DATA_W < 27) begin : g_bad_data_w
      $error("DATA_W must hold the widest idle field (bit 26)");
   end
   if (ADDR_W < 16) begin : g_bad_addr_w
      $error("ADDR_W must hold the 16-bit register offsets");
   end
   if (DRAIN_XG < 1 || DRAIN_GE < 1 || POLL_XG < 1 || POLL_GE < 1 || RST_POLL < 1) begin : g_bad_wait
      $error("every wait interval must be at least one cycle");
   end
   if (LIMIT_TX < 1 || LIMIT_RX < 1) begin : g_bad_limit
      $error("poll limits must be at least one");
   end

   seq_state_e        state_q, state_d;
   logic              kind_q, dir_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] cfg_save_q, rst_img_q;
   logic              err_q;

   logic [ADDR_W-1:0] cfg_addr, sm_addr, rst_addr;
   logic [DATA_W-1:0] en_mask, idle_mask, rst_mask;
   logic [TMR_W-1:0]  drain_rld, poll_rld, rst_rld;
   logic [LIM_W-1:0]  limit, tally;

   logic              tmr_load, tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic              tally_clr, tally_inc, set_err;
   logic              accept, hs;

   mwr_profile #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .TMR_W   (TMR_W),
      .LIM_W   (LIM_W),
      .DRAIN_XG(DRAIN_XG),
      .DRAIN_GE(DRAIN_GE),
      .POLL_XG (POLL_XG),
      .POLL_GE (POLL_GE),
      .RST_POLL(RST_POLL),
      .LIMIT_TX(LIMIT_TX),
      .LIMIT_RX(LIMIT_RX)
   ) u_profile (
      .kind_i     (kind_q),
      .dir_i      (dir_q),
      .base_i     (base_q),
      .cfg_addr_o (cfg_addr),
      .sm_addr_o  (sm_addr),
      .rst_addr_o (rst_addr),
      .en_mask_o  (en_mask),
      .idle_mask_o(idle_mask),
      .rst_mask_o (rst_mask),
      .drain_rld_o(drain_rld),
      .poll_rld_o (poll_rld),
      .rst_rld_o  (rst_rld),
      .limit_o    (limit)
   );

   mwr_timer #(.W(TMR_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load),
      .value_i(tmr_val),
      .zero_o (tmr_zero)
   );

   mwr_tally #(.W(LIM_W)) u_tally (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tally_clr),
      .inc_i  (tally_inc),
      .count_o(tally)
   );

   assign busy_o = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign done_o = (state_q == ST_FIN);
   assign err_o  = err_q;
   assign accept = start_i && !busy_o;
   assign hs     = bus_req_o && bus_ready_i;

   // bus drive, decoded from the current step
   always_comb begin
      bus_req_o   = 1'b0;
      bus_we_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      unique case (state_q)
         ST_CFG_RD: begin
            bus_req_o  = 1'b1;
            bus_addr_o = cfg_addr;
         end
         ST_CFG_WR: begin
            bus_req_o   = 1'b1;
            bus_we_o    = 1'b1;
            bus_addr_o  = cfg_addr;
            bus_wdata_o = cfg_save_q & ~en_mask;
         end
         ST_IDLE_RD: begin
            bus_req_o  = 1'b1;
            bus_addr_o = sm_addr;
         end
         ST_RST_RD, ST_RST_CHK: begin
            bus_req_o  = 1'b1;
            bus_addr_o = rst_addr;
         end
         ST_RST_WR: begin
            bus_req_o   = 1'b1;
            bus_we_o    = 1'b1;
            bus_addr_o  = rst_addr;
            bus_wdata_o = rst_img_q | rst_mask;
         end
         ST_RESTORE: begin
            bus_req_o   = 1'b1;
            bus_we_o    = 1'b1;
            bus_addr_o  = cfg_addr;
            bus_wdata_o = cfg_save_q;
         end
         default: ;
      endcase
   end

   // step sequencing
   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      tally_clr = 1'b0;
      tally_inc = 1'b0;
      set_err   = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_FIN: state_d = start_i ? ST_CFG_RD : ST_IDLE;
         ST_CFG_RD: if (hs) state_d = ST_CFG_WR;
         ST_CFG_WR: if (hs) begin
            state_d   = ST_DRAIN;
            tmr_load  = 1'b1;
            tmr_val   = drain_rld;
            tally_clr = 1'b1;
         end
         ST_DRAIN, ST_IDLE_GAP: if (tmr_zero) state_d = ST_IDLE_RD;
         ST_IDLE_RD: if (hs) begin
            if ((bus_rdata_i & idle_mask) == '0) begin
               state_d = ST_RST_RD;
            end else if (tally == limit) begin
               state_d = ST_FIN;
               set_err = 1'b1;
            end else begin
               state_d   = ST_IDLE_GAP;
               tally_inc = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = poll_rld;
            end
         end
         ST_RST_RD: if (hs) state_d = ST_RST_WR;
         ST_RST_WR: if (hs) begin
            state_d   = ST_RST_GAP;
            tmr_load  = 1'b1;
            tmr_val   = rst_rld;
            tally_clr = 1'b1;
         end
         ST_RST_GAP: if (tmr_zero) state_d = ST_RST_CHK;
         ST_RST_CHK: if (hs) begin
            if ((bus_rdata_i & rst_mask) == '0) begin
               state_d = ST_RESTORE;
            end else if (tally == limit) begin
               state_d = ST_FIN;
               set_err = 1'b1;
            end else begin
               state_d   = ST_RST_GAP;
               tally_inc = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = rst_rld;
            end
         end
         ST_RESTORE: if (hs) state_d = ST_FIN;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         kind_q     <= 1'b0;
         dir_q      <= 1'b0;
         base_q     <= '0;
         cfg_save_q <= '0;
         rst_img_q  <= '0;
         err_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            kind_q <= kind_i;
            dir_q  <= dir_i;
            base_q <= port_base_i;
            err_q  <= 1'b0;
         end else if (set_err) begin
            err_q <= 1'b1;
         end
         if (state_q == ST_CFG_RD && hs) cfg_save_q <= bus_rdata_i;
         if (state_q == ST_RST_RD && hs) rst_img_q  <= bus_rdata_i;
      end
   end

endmodule

// File: rtl/mwr_chk.sv
module mwr_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata
);

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy); // R11

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)); // R11

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R1

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err && !(start && !busy) |=> err); // R10

   AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !bus_req); // R9

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R9

endmodule

bind mac_warm_rst_seq mwr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mwr_chk (
   .clk      (clk_i),
   .rst_n    (rst_ni),
   .start    (start_i),
   .busy     (busy_o),
   .done     (done_o),
   .err      (err_o),
   .bus_req  (bus_req_o),
   .bus_we   (bus_we_o),
   .bus_ready(bus_ready_i),
   .bus_addr (bus_addr_o),
   .bus_wdata(bus_wdata_o)
);

// File: tb/mac_warm_rst_seq_bench.sv
module mac_warm_rst_seq_bench;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int DXG = 12;
   localparam int DGE = 40;
   localparam int PXG = 5;
   localparam int PGE = 9;
   localparam int RP  = 4;
   localparam int LTX = 100;
   localparam int LRX = 10;
   localparam int WD_LIMIT = 150000;

   typedef struct {
      logic [AW-1:0] a;
      logic          w;
      logic [DW-1:0] wd;
      logic [DW-1:0] rd;
      int            gap;
      string         tag;
      string         gtag;
   } acc_t;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start, kind, dir;
   logic [AW-1:0] base;
   logic          bus_req, bus_we, bus_ready;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          busy, done, err;

   always #10 clk = ~clk;

   mac_warm_rst_seq #(
      .ADDR_W(AW), .DATA_W(DW), .DRAIN_XG(DXG), .DRAIN_GE(DGE),
      .POLL_XG(PXG), .POLL_GE(PGE), .RST_POLL(RP), .LIMIT_TX(LTX), .LIMIT_RX(LRX)
   ) u_mac_warm_rst_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind), .dir_i(dir),
      .port_base_i(base), .bus_req_o(bus_req), .bus_we_o(bus_we),
      .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready),
      .bus_rdata_i(bus_rdata), .busy_o(busy), .done_o(done), .err_o(err)
   );

   acc_t exp_q[$];
   int   n_chk = 0, n_err = 0, nedge = 0, last_hs = 0, lat_cnt = 0, lat = 0;
   bit   in_acc = 0, running = 0, exp_err = 0, exp_timeout = 0, wd_hit = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic push(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] wd,
                       input logic [DW-1:0] rd, input int gap, input string tag,
                       input string gtag);
      acc_t e;
      e.a = a; e.w = w; e.wd = wd; e.rd = rd; e.gap = gap; e.tag = tag; e.gtag = gtag;
      exp_q.push_back(e);
   endtask

   // expected access list built from the requirements
   task automatic plan(input bit k, input bit d, input logic [AW-1:0] b,
                       input logic [DW-1:0] cfg, input int sm_n,
                       input logic [DW-1:0] sm_busy, input logic [DW-1:0] sm_idle,
                       input logic [DW-1:0] rst_init, input int rst_busy_n);
      logic [AW-1:0] cfg_a, sm_a, rst_a;
      logic [DW-1:0] en, rmask;
      int drain, poll, limit;
      exp_timeout = 0;
      if (!k) begin
         cfg_a = b + 16'h0060; sm_a = b + 16'h01A8;
         rst_a = b + (d ? 16'h0008 : 16'h0000);
         en = d ? 32'h100 : 32'h1; rmask = 32'h3; drain = DXG; poll = PXG;
      end else begin
         cfg_a = b + (d ? 16'hC068 : 16'hC060); sm_a = b + 16'hC3A0;
         rst_a = b + (d ? 16'hC008 : 16'hC000);
         en = 32'h1; rmask = 32'h1; drain = DGE; poll = PGE;
      end
      limit = d ? LRX : LTX;
      push(cfg_a, 1'b0, '0, cfg, 1, "R2", "R2");
      push(cfg_a, 1'b1, cfg & ~en, '0, 1, "R2", "R2");
      for (int i = 0; ; i++) begin
         push(sm_a, 1'b0, '0, (i < sm_n) ? sm_busy : sm_idle,
              (i == 0) ? drain + 1 : poll + 1, "R4", (i == 0) ? "R3" : "R4");
         if (i >= sm_n) break;
         if (i == limit) begin exp_timeout = 1; return; end
      end
      push(rst_a, 1'b0, '0, rst_init, 1, "R6", "R5");
      push(rst_a, 1'b1, rst_init | rmask, '0, 1, "R6", "R6");
      for (int i = 0; ; i++) begin
         push(rst_a, 1'b0, '0, (i < rst_busy_n) ? (rst_init | rmask) : (rst_init & ~rmask),
              RP + 1, "R7", "R7");
         if (i >= rst_busy_n) break;
         if (i == limit) begin exp_timeout = 1; return; end
      end
      push(cfg_a, 1'b1, cfg, '0, 1, "R8", "R8");
   endtask

   // one clock: check outputs, act as bus slave, update the model, drive start
   task automatic step(input bit st);
      bit dn;
      acc_t e;
      @(negedge clk);
      nedge++;
      if (nedge > WD_LIMIT) wd_hit = 1;
      dn = running && exp_q.size() == 0 && !in_acc && nedge == last_hs + 1;
      if (dn) exp_err = exp_timeout;
      chk(busy == (running && !dn), "R1", "busy", 64'(busy), 64'(running && !dn));
      chk(done == dn, "R8", "done", 64'(done), 64'(dn));
      chk(err == exp_err, exp_timeout ? "R9" : "R10", "err", 64'(err), 64'(exp_err));
      if (dn) running = 0;
      bus_ready = 1'b0;
      if (bus_req && !in_acc) begin
         in_acc = 1; lat_cnt = 0;
         if (exp_q.size() != 0)
            chk(nedge - last_hs == exp_q[0].gap, exp_q[0].gtag, "request gap",
                64'(nedge - last_hs), 64'(exp_q[0].gap));
      end
      if (bus_req && in_acc) begin
         if (lat_cnt == lat) begin
            bus_ready = 1'b1; in_acc = 0; last_hs = nedge;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected access", {15'd0, bus_addr, bus_we, bus_wdata}, 64'd0);
               bus_rdata = '0;
            end else begin
               e = exp_q.pop_front();
               chk(bus_addr == e.a && bus_we == e.w && (!e.w || bus_wdata == e.wd), e.tag,
                   "access {addr,we,wdata}", {15'd0, bus_addr, bus_we, bus_wdata},
                   {15'd0, e.a, e.w, e.w ? e.wd : bus_wdata});
               bus_rdata = e.rd;
            end
         end else lat_cnt++;
      end else if (!bus_req && in_acc) begin
         chk(1'b0, "R11", "request dropped before ready", 64'd0, 64'd1);
         in_acc = 0;
      end
      start = st;
      if (st && !running) begin
         running = 1; last_hs = nedge; exp_err = 0;
      end
   endtask

   task automatic run(input bit k, input bit d, input logic [AW-1:0] b, input int latency,
                      input bit poke, input logic [DW-1:0] cfg, input int sm_n,
                      input logic [DW-1:0] sm_busy, input logic [DW-1:0] sm_idle,
                      input logic [DW-1:0] rst_init, input int rst_busy_n);
      kind = k; dir = d; base = b; lat = latency;
      plan(k, d, b, cfg, sm_n, sm_busy, sm_idle, rst_init, rst_busy_n);
      step(1'b1);
      while (running && !wd_hit) begin
         if (poke && (nedge % 7 == 0) && exp_q.size() > 1) begin
            // R1: selects and base move, start repeats, all mid-run
            kind = ~kind; dir = ~dir; base = base + 16'h0100;
            step(1'b1);
         end else step(1'b0);
      end
      for (int i = 0; i < 4; i++) step(1'b0);
      chk(exp_q.size() == 0, exp_timeout ? "R9" : "R8", "accesses left",
          64'(exp_q.size()), 64'd0);
      exp_q.delete();
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; kind = 1'b0; dir = 1'b0; base = '0;
      bus_ready = 1'b0; bus_rdata = '0;
      repeat (3) @(negedge clk);
      // R12: quiet outputs in reset
      chk({busy, done, err, bus_req} == 4'b0000, "R12", "reset outputs",
          64'({busy, done, err, bus_req}), 64'd0);
      rst_n = 1'b1;
      step(1'b0);
      // 10G tx, immediate ready, two busy state reads, one busy reset read
      run(1'b0, 1'b0, 16'h1000, 0, 1'b0, 32'hABCD_0F0F, 2, 32'h0000_0005,
          32'h0000_FFF8, 32'h0000_00F0, 1);
      // 10G rx, slow ready, exactly the limit of busy reads; bits outside bit 7 set
      run(1'b0, 1'b1, 16'h0200, 2, 1'b0, 32'h0000_0301, LRX, 32'h0000_0080,
          32'hFFFF_FF7F, 32'h1234_0000, 0);
      // 1G tx, mid-run start pulses and select changes ignored
      run(1'b1, 1'b0, 16'h0800, 1, 1'b1, 32'h5555_AAAB, 3, 32'h0001_0000,
          32'hFFF0_FFFF, 32'h0000_0EE2, 2);
      // 1G rx, no waiting anywhere; 10G field bits set in the idle value
      run(1'b1, 1'b1, 16'h0010, 0, 1'b0, 32'hFFFF_FFFF, 0, 32'h0400_0000,
          32'hF87F_FFFF, 32'h0000_0006, 0);
      // 10G rx, state never idles: timeout after LRX+1 reads, no restore
      run(1'b0, 1'b1, 16'h0040, 0, 1'b0, 32'h0000_0100, 1000, 32'h0000_0080,
          32'h0, 32'h0, 0);
      // R10: error holds while idle
      for (int i = 0; i < 10; i++) step(1'b0);
      // 1G tx, reset bit never clears: timeout in the reset loop
      run(1'b1, 1'b0, 16'h0300, 0, 1'b0, 32'h0000_0011, 0, 32'h0,
          32'h0, 32'h0000_0010, 1000);
      // 10G tx normal run clears the error at start
      run(1'b0, 1'b0, 16'h0000, 1, 1'b0, 32'h0000_0001, 0, 32'h0,
          32'hFFFF_FFF8, 32'h0, 0);
      if (wd_hit) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", nedge, WD_LIMIT);
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule